// File: doc/BRIEF.md
# High-Order Path Remote Defect Indication Monitor and Generator

This block watches the path status byte that arrives once per high-order path frame. It takes the three remote-defect bits of that byte and accepts a new value only after the same value has been seen in a programmable number of consecutive frames. From the accepted value it reports a remote defect alarm and a decoded defect class. The bits can be read in plain form, where one bit carries the indication, or in enhanced form, where the three-bit code names the class of the far-end defect.

In the other direction the block turns local defect flags into the three remote-defect bits and the spare bit of the outgoing status byte. There are four such flags: a server-layer defect, a signal label mismatch, a trace mismatch and an unequipped path. A loss of ATM cell delineation is a fifth input. Each source other than the server flag has its own enable, and the label mismatch can be mapped to a payload class or a connectivity class. Two plain codings and one enhanced coding are available.

The receive side is a stream input with valid/ready. `g1_ready` is always high, so the block never applies back-pressure. A status byte is consumed in every clock cycle in which `g1_valid` is high, and cycles with `g1_valid` low carry no frame. The configuration and defect pins are plain level inputs.

Top module: `hp_rdi_unit`

## Requirements
- R1: The field `cfg_depth_sel` sets the run length needed to accept a received code: 0 gives 3 frames, 1 gives 5, 2 gives 10 and 3 gives 16. The accepted code is `g1_byte[3:1]`, where `g1_byte[3]` is the first remote-defect bit. It changes, and the outputs follow, on the clock edge that consumes the frame completing the run, and not one frame earlier.
- R2: A frame whose three-bit code differs from the previous frame restarts the run at one. This holds even if both codes mean a defect.
- R3: A raised alarm falls only after a full run of frames carrying a code that decodes to no defect.
- R4: With `cfg_enh_detect`=0, a code whose first bit is 1 raises `rdi_alarm` and reports the server class. Any other code reports no defect.
- R5: With `cfg_enh_detect`=1, the codes decode as follows: 010 is payload, 101 is server and 110 is connectivity. All other codes mean no defect. `rdi_type` encodes none as 0, payload as 1, server as 2 and connectivity as 3. `rdi_alarm` is high exactly when the class is not none.
- R6: Cycles with `g1_valid` low neither advance nor restart a run, whatever `g1_byte` carries.
- R7: With `cfg_tx_mode`=0, `tx_g1_low[3:1]` is 100 while any enabled defect is present and 000 otherwise.
- R8: With `cfg_tx_mode`=1, `tx_g1_low[3:1]` is 111 while any enabled defect is present and 011 otherwise.
- R9: With `cfg_tx_mode`=2 or 3, `tx_g1_low[3:1]` sends the enhanced code for the highest-ranking defect present, or 001 when no defect is present. Server ranks above connectivity, and connectivity ranks above payload.
- R10: `cfg_slm_map` sets how a label mismatch is used: 2 makes it a connectivity defect, 3 makes it a payload defect, and 0 or 1 means it is ignored.
- R11: `cfg_en_tim` and `cfg_en_uneq` let the trace and unequipped flags act as connectivity defects, and `cfg_en_lcd` lets cell delineation loss act as a payload defect. When an enable is low, its flag has no effect on `tx_g1_low`. The server flag is always active.
- R12: `tx_g1_low[0]` carries `cfg_spare`. `tx_g1_low` is registered and reflects inputs sampled at the previous clock edge.
- R13: While `rst_n` is low, `rdi_alarm`=0, `rdi_type`=0 and `tx_g1_low`=0000. `g1_ready` is 1 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| g1_valid | input | 1 | A received status byte is present |
| g1_ready | output | 1 | Always 1; the block never stalls |
| g1_byte | input | 8 | Received path status byte |
| cfg_depth_sel | input | 2 | Persistence depth select |
| cfg_enh_detect | input | 1 | 1 selects enhanced receive decoding |
| cfg_tx_mode | input | 2 | Transmit coding: 0 plain A, 1 plain B, 2 or 3 enhanced |
| cfg_slm_map | input | 2 | Label mismatch mapping |
| cfg_en_tim | input | 1 | Trace mismatch enable |
| cfg_en_uneq | input | 1 | Unequipped enable |
| cfg_en_lcd | input | 1 | Cell delineation loss enable |
| cfg_spare | input | 1 | Value of the outgoing spare bit |
| def_srv | input | 1 | Local server-layer defect |
| def_slm | input | 1 | Local signal label mismatch |
| def_tim | input | 1 | Local trace mismatch |
| def_uneq | input | 1 | Local unequipped path |
| def_lcd | input | 1 | Local loss of cell delineation |
| rdi_alarm | output | 1 | Remote defect declared |
| rdi_type | output | 2 | Decoded remote defect class |
| tx_g1_low | output | 4 | Outgoing remote-defect bits and spare bit |

## Verification
The assertions assume two things about the inputs. First, `cfg_enh_detect` only changes in a cycle where the alarm is allowed to move without a frame, so the check that a rising alarm needs a consumed frame is waived on any edge where that bit changed. Second, `cfg_tx_mode` and the defect flags are sampled once per clock, so each transmit property compares with the values from the previous edge. The stimulus changes the persistence depth and the decoding mode only while reset is applied or before a fresh run begins. It drives arbitrary bytes during idle cycles so that the rule about absent frames is exercised.

// File: rtl/hp_rdi_pkg.sv
package hp_rdi_pkg;

  localparam int RDI_W = 3;

  typedef enum logic [1:0] {
    DEF_NONE    = 2'd0,
    DEF_PAYLOAD = 2'd1,
    DEF_SERVER  = 2'd2,
    DEF_CONNECT = 2'd3
  } defect_e;

  typedef enum logic [1:0] {
    TXM_PLAIN_A = 2'd0,
    TXM_PLAIN_B = 2'd1,
    TXM_ENH     = 2'd2,
    TXM_RSVD    = 2'd3
  } tx_mode_e;

  localparam logic [RDI_W-1:0] ENH_PAYLOAD = 3'b010;
  localparam logic [RDI_W-1:0] ENH_SERVER  = 3'b101;
  localparam logic [RDI_W-1:0] ENH_CONNECT = 3'b110;
  localparam logic [RDI_W-1:0] ENH_CLEAR   = 3'b001;
  localparam logic [RDI_W-1:0] PLA_SET     = 3'b100;
  localparam logic [RDI_W-1:0] PLA_CLEAR   = 3'b000;
  localparam logic [RDI_W-1:0] PLB_SET     = 3'b111;
  localparam logic [RDI_W-1:0] PLB_CLEAR   = 3'b011;

  localparam logic [1:0] SLM_AS_CONNECT = 2'd2;
  localparam logic [1:0] SLM_AS_PAYLOAD = 2'd3;

endpackage

// File: rtl/rdi_decode.sv
module rdi_decode
  import hp_rdi_pkg::*;
(
  input  logic [RDI_W-1:0] code,
  input  logic             enhanced,
  output defect_e          kind
);

  always_comb begin
    kind = DEF_NONE;
    if (enhanced) begin
      case (code)
        ENH_PAYLOAD: kind = DEF_PAYLOAD;
        ENH_SERVER:  kind = DEF_SERVER;
        ENH_CONNECT: kind = DEF_CONNECT;
        default:     kind = DEF_NONE;
      endcase
    end else if (code[RDI_W-1]) begin
      kind = DEF_SERVER;
    end
  end

endmodule

// File: rtl/rdi_persist.sv
module rdi_persist
  import hp_rdi_pkg::*;
#(
  parameter int DEPTH0 = 3,
  parameter int DEPTH1 = 5,
  parameter int DEPTH2 = 10,
  parameter int DEPTH3 = 16,
  parameter int CNT_W  = 5
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_vld,
  input  logic [RDI_W-1:0] code,
  input  logic [1:0]       depth_sel,
  output logic [RDI_W-1:0] accepted
);

  logic [CNT_W-1:0] need;
  logic [CNT_W-1:0] run_q, run_inc, run_next;
  logic [RDI_W-1:0] last_q, acc_q;

  always_comb begin
    case (depth_sel)
      2'd0:    need = CNT_W'(DEPTH0);
      2'd1:    need = CNT_W'(DEPTH1);
      2'd2:    need = CNT_W'(DEPTH2);
      default: need = CNT_W'(DEPTH3);
    endcase
  end

  always_comb begin
    run_inc  = (run_q >= need) ? need : run_q + CNT_W'(1);
    run_next = (code == last_q) ? run_inc : CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      run_q  <= '0;
      acc_q  <= '0;
    end else if (frame_vld) begin
      last_q <= code;
      run_q  <= run_next;
      if (run_next == need) acc_q <= code;
    end
  end

  assign accepted = acc_q;

  // R2: a differing code restarts the run
  p_change_restarts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_vld && code != last_q) |=> (run_q == CNT_W'(1)));

  // R6: idle cycles hold the run state
  p_idle_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_vld |=> ($stable(run_q) && $stable(last_q) && $stable(acc_q)));

  // R1: the accepted code only moves on a consumed frame
  p_accept_on_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(acc_q) |-> $past(frame_vld));

endmodule

// File: rtl/rdi_encode.sv
module rdi_encode
  import hp_rdi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic [1:0] slm_map,
  input  logic       en_tim,
  input  logic       en_uneq,
  input  logic       en_lcd,
  input  logic       spare,
  input  logic       d_srv,
  input  logic       d_slm,
  input  logic       d_tim,
  input  logic       d_uneq,
  input  logic       d_lcd,
  output logic [3:0] g1_low
);

  logic             pay, con, any;
  logic [RDI_W-1:0] bits;
  logic [3:0]       g1_q;

  always_comb begin
    pay = (en_lcd & d_lcd) | (d_slm & (slm_map == SLM_AS_PAYLOAD));
    con = (en_tim & d_tim) | (en_uneq & d_uneq) | (d_slm & (slm_map == SLM_AS_CONNECT));
    any = pay | con | d_srv;
    case (tx_mode_e'(mode))
      TXM_PLAIN_A: bits = any ? PLA_SET : PLA_CLEAR;
      TXM_PLAIN_B: bits = any ? PLB_SET : PLB_CLEAR;
      default: begin
        if (d_srv)    bits = ENH_SERVER;
        else if (con) bits = ENH_CONNECT;
        else if (pay) bits = ENH_PAYLOAD;
        else          bits = ENH_CLEAR;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) g1_q <= '0;
    else        g1_q <= {bits, spare};
  end

  assign g1_low = g1_q;

  // R7: plain A never sets the trailing two code bits
  p_plain_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0) |=> (g1_low[2:1] == 2'b00));

  // R8: plain B always sets the trailing two code bits
  p_plain_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1) |=> (g1_low[2:1] == 2'b11));

  // R9: server outranks every other class in enhanced coding
  p_server_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] && d_srv) |=> (g1_low[3:1] == 3'b101));

endmodule

// File: rtl/hp_rdi_unit.sv
module hp_rdi_unit
  import hp_rdi_pkg::*;
#(
  parameter int DEPTH0 = 3,
  parameter int DEPTH1 = 5,
  parameter int DEPTH2 = 10,
  parameter int DEPTH3 = 16
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       g1_valid,
  output logic       g1_ready,
  input  logic [7:0] g1_byte,
  input  logic [1:0] cfg_depth_sel,
  input  logic       cfg_enh_detect,
  input  logic [1:0] cfg_tx_mode,
  input  logic [1:0] cfg_slm_map,
  input  logic       cfg_en_tim,
  input  logic       cfg_en_uneq,
  input  logic       cfg_en_lcd,
  input  logic       cfg_spare,
  input  logic       def_srv,
  input  logic       def_slm,
  input  logic       def_tim,
  input  logic       def_uneq,
  input  logic       def_lcd,
  output logic       rdi_alarm,
  output logic [1:0] rdi_type,
  output logic [3:0] tx_g1_low
);

  localparam int MAX_A = (DEPTH0 > DEPTH1) ? DEPTH0 : DEPTH1;
  localparam int MAX_B = (DEPTH2 > DEPTH3) ? DEPTH2 : DEPTH3;
  localparam int MAX_D = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAX_D + 1);

  logic             frame_vld;
  logic [RDI_W-1:0] acc_code;
  defect_e          kind;

  assign g1_ready  = 1'b1;
  assign frame_vld = g1_valid & g1_ready;

  rdi_persist #(
    .DEPTH0(DEPTH0), .DEPTH1(DEPTH1), .DEPTH2(DEPTH2), .DEPTH3(DEPTH3), .CNT_W(CNT_W)
  ) u_persist (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_vld (frame_vld),
    .code      (g1_byte[3:1]),
    .depth_sel (cfg_depth_sel),
    .accepted  (acc_code)
  );

  rdi_decode u_decode (
    .code     (acc_code),
    .enhanced (cfg_enh_detect),
    .kind     (kind)
  );

  assign rdi_type  = kind;
  assign rdi_alarm = (kind != DEF_NONE);

  rdi_encode u_encode (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (cfg_tx_mode),
    .slm_map (cfg_slm_map),
    .en_tim  (cfg_en_tim),
    .en_uneq (cfg_en_uneq),
    .en_lcd  (cfg_en_lcd),
    .spare   (cfg_spare),
    .d_srv   (def_srv),
    .d_slm   (def_slm),
    .d_tim   (def_tim),
    .d_uneq  (def_uneq),
    .d_lcd   (def_lcd),
    .g1_low  (tx_g1_low)
  );

  // R1: with decoding mode steady, a rising alarm needs a consumed frame
  p_alarm_needs_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rdi_alarm) && $stable(cfg_enh_detect)) |-> $past(frame_vld));

endmodule

// File: tb/sim_hp_rdi_unit.sv
`timescale 1ns/1ps
module sim_hp_rdi_unit;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       g1_valid = 1'b0;
  logic       g1_ready;
  logic [7:0] g1_byte = 8'h00;
  logic [1:0] cfg_depth_sel = 2'd0;
  logic       cfg_enh_detect = 1'b0;
  logic [1:0] cfg_tx_mode = 2'd0;
  logic [1:0] cfg_slm_map = 2'd0;
  logic       cfg_en_tim = 1'b0, cfg_en_uneq = 1'b0, cfg_en_lcd = 1'b0, cfg_spare = 1'b0;
  logic       def_srv = 1'b0, def_slm = 1'b0, def_tim = 1'b0, def_uneq = 1'b0, def_lcd = 1'b0;
  logic       rdi_alarm;
  logic [1:0] rdi_type;
  logic [3:0] tx_g1_low;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hp_rdi_unit u0 (
    .clk(clk), .rst_n(rst_n), .g1_valid(g1_valid), .g1_ready(g1_ready), .g1_byte(g1_byte),
    .cfg_depth_sel(cfg_depth_sel), .cfg_enh_detect(cfg_enh_detect), .cfg_tx_mode(cfg_tx_mode),
    .cfg_slm_map(cfg_slm_map), .cfg_en_tim(cfg_en_tim), .cfg_en_uneq(cfg_en_uneq),
    .cfg_en_lcd(cfg_en_lcd), .cfg_spare(cfg_spare), .def_srv(def_srv), .def_slm(def_slm),
    .def_tim(def_tim), .def_uneq(def_uneq), .def_lcd(def_lcd),
    .rdi_alarm(rdi_alarm), .rdi_type(rdi_type), .tx_g1_low(tx_g1_low)
  );

  // fields: mode[16:15] slm_map[14:13] en{tim,uneq,lcd}[12:10] spare[9]
  //         def{srv,slm,tim,uneq,lcd}[8:4] expected tx_g1_low[3:0]
  localparam int NV = 16;
  localparam logic [16:0] TXV [NV] = '{
    {2'd0, 2'd0, 3'b111, 1'b0, 5'b00000, 4'b0000},  // R7 clear
    {2'd0, 2'd0, 3'b111, 1'b1, 5'b00100, 4'b1001},  // R7 set, R12 spare
    {2'd1, 2'd0, 3'b111, 1'b0, 5'b00000, 4'b0110},  // R8 clear
    {2'd1, 2'd0, 3'b111, 1'b0, 5'b00001, 4'b1110},  // R8 set
    {2'd1, 2'd0, 3'b000, 1'b0, 5'b00111, 4'b0110},  // R11 all disabled
    {2'd2, 2'd0, 3'b000, 1'b0, 5'b00000, 4'b0010},  // R9 no defect
    {2'd2, 2'd0, 3'b001, 1'b0, 5'b00001, 4'b0100},  // R9 payload
    {2'd2, 2'd0, 3'b010, 1'b0, 5'b00010, 4'b1100},  // R9 connectivity
    {2'd2, 2'd0, 3'b111, 1'b1, 5'b00111, 4'b1101},  // R9 conn over payload
    {2'd2, 2'd0, 3'b111, 1'b0, 5'b10111, 4'b1010},  // R9 server wins
    {2'd2, 2'd2, 3'b000, 1'b0, 5'b01000, 4'b1100},  // R10 slm conn
    {2'd2, 2'd3, 3'b000, 1'b0, 5'b01000, 4'b0100},  // R10 slm payload
    {2'd2, 2'd0, 3'b000, 1'b0, 5'b01000, 4'b0010},  // R10 slm ignored
    {2'd0, 2'd3, 3'b000, 1'b0, 5'b01000, 4'b1000},  // R10 slm plain
    {2'd3, 2'd3, 3'b001, 1'b0, 5'b01001, 4'b0100},  // R9 reserved mode
    {2'd0, 2'd0, 3'b000, 1'b0, 5'b10000, 4'b1000}   // R11 server always on
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic frame(input logic [7:0] b);
    g1_byte  = b;
    g1_valid = 1'b1;
    @(negedge clk);
    g1_valid = 1'b0;
    g1_byte  = 8'hFF;
  endtask

  task automatic frames(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) frame(b);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin : watchdog
    #(5 * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    @(negedge clk);
    @(negedge clk);
    // R13 reset state
    chk("R13 alarm in reset", {7'd0, rdi_alarm}, 8'd0);
    chk("R13 type in reset", {6'd0, rdi_type}, 8'd0);
    chk("R13 tx in reset", {4'd0, tx_g1_low}, 8'd0);
    chk("R13 ready", {7'd0, g1_ready}, 8'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // transmit table walk
    for (int v = 0; v < NV; v++) begin
      {cfg_tx_mode, cfg_slm_map, cfg_en_tim, cfg_en_uneq, cfg_en_lcd, cfg_spare,
       def_srv, def_slm, def_tim, def_uneq, def_lcd} = TXV[v][16:4];
      @(negedge clk);
      chk($sformatf("R7-R12 vector %0d", v), {4'd0, tx_g1_low}, {4'd0, TXV[v][3:0]});
    end

    // R1 R4 depth 3, plain
    cfg_depth_sel = 2'd0; cfg_enh_detect = 1'b0;
    do_reset();
    frames(8'h58, 2);
    chk("R1 no alarm after 2 of 3", {7'd0, rdi_alarm}, 8'd0);
    frame(8'h59);
    chk("R1 alarm after 3", {7'd0, rdi_alarm}, 8'd1);
    chk("R4 plain type server", {6'd0, rdi_type}, 8'd2);
    // R3 clear
    frames(8'h30, 2);
    chk("R3 alarm held after 2 clear", {7'd0, rdi_alarm}, 8'd1);
    frame(8'h30);
    chk("R3 alarm cleared after 3", {7'd0, rdi_alarm}, 8'd0);

    // R2 depth 5
    cfg_depth_sel = 2'd1;
    do_reset();
    frames(8'h08, 4);
    frame(8'h0A);
    chk("R2 run restarted on change", {7'd0, rdi_alarm}, 8'd0);
    frames(8'h0A, 3);
    chk("R2 4 of 5 after restart", {7'd0, rdi_alarm}, 8'd0);
    frame(8'h0A);
    chk("R2 alarm after new run of 5", {7'd0, rdi_alarm}, 8'd1);

    // R6 depth 10 with idle gaps carrying other bytes
    cfg_depth_sel = 2'd2;
    do_reset();
    for (int i = 0; i < 9; i++) begin
      frame(8'h0C);
      g1_byte = 8'h00;
      repeat (3) @(negedge clk);
    end
    chk("R6 9 of 10 with gaps", {7'd0, rdi_alarm}, 8'd0);
    frame(8'h0C);
    chk("R6 alarm at 10 with gaps", {7'd0, rdi_alarm}, 8'd1);

    // R1 depth 16
    cfg_depth_sel = 2'd3;
    do_reset();
    frames(8'h09, 15);
    chk("R1 no alarm at 15 of 16", {7'd0, rdi_alarm}, 8'd0);
    frame(8'h09);
    chk("R1 alarm at 16", {7'd0, rdi_alarm}, 8'd1);

    // R5 enhanced decoding, depth 3
    cfg_depth_sel = 2'd0; cfg_enh_detect = 1'b1;
    do_reset();
    frames(8'hA4, 3);
    chk("R5 payload type", {6'd0, rdi_type}, 8'd1);
    chk("R5 payload alarm", {7'd0, rdi_alarm}, 8'd1);
    frames(8'h0C, 3);
    chk("R5 connectivity type", {6'd0, rdi_type}, 8'd3);
    frames(8'h0A, 3);
    chk("R5 server type", {6'd0, rdi_type}, 8'd2);
    frames(8'h08, 3);
    chk("R5 100 is no defect when enhanced", {7'd0, rdi_alarm}, 8'd0);
    frames(8'h0A, 3);
    frames(8'h06, 3);
    chk("R5 011 clears", {6'd0, rdi_type}, 8'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule